// File: doc/BRIEF.md
# Iterative AES-128 Encryption Engine

This block encrypts one 128-bit block with a 128-bit key and finishes one complete cipher round in every clock cycle. The state loop has a single register, placed at the byte-substitution stage. Every other transform is combinational and sits around a loop selector. In the first cycle the selector takes the plaintext. In every later cycle it takes the transformed state. The round-key generator runs alongside the state loop and hands over a fresh round key every cycle. An encryption therefore takes eleven cycles, counting the cycle in which start is sampled. The column-mixing step is skipped in the last round.

The block is used as a fixed-latency cipher core. The user places the plaintext and the key on the inputs and raises start for one cycle. The block then raises a round-activity output for the whole run, so that outside test equipment can line up with the rounds. When the result is ready, a one-cycle done pulse marks it. The ciphertext stays on its own output bus until the next encryption completes.

Top module: `aes128_loop_enc`

## Requirements
- R1: While reset (rst_n low) is applied, and after its release until the first start, done_o and trig_o are 0 and ct_o is all zeros.
- R2: ct_o equals the AES-128 encryption of pt_i under key_i as sampled with start. Bytes are numbered from the most significant byte: byte 0 is bits 127:120, and state byte (row r, column c) is byte r+4c.
- R3: done_o is 1 in the cycle after the 11th rising edge, counting as the first the edge that samples an accepted start.
- R4: done_o is high for exactly one cycle per encryption.
- R5: ct_o changes only at the edge where done_o rises. It holds its value until the next encryption completes.
- R6: trig_o rises at the edge that accepts start. It stays high for exactly 10 cycles and is low whenever done_o is high.
- R7: A start that arrives while trig_o is high is ignored. It does not change the result, the timing or the number of done pulses.
- R8: A start that arrives in the cycle in which done_o is high is accepted, so runs can follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| pt_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| ct_o | output | 128 | Ciphertext, held until the next result |
| done_o | output | 1 | One-cycle result-valid pulse |
| trig_o | output | 1 | High while rounds are being computed |

## Verification
Four published key and plaintext pairs are used: an all-zero pair, an incrementing-byte pair and two pairs sharing one key. Between them they separate errors in byte order, in the ShiftRows rotation direction, in the round-constant sequence and in the last-round column-mixing bypass, because each such error corrupts every vector differently. One run carries a second start, with different data, part way through. A restart would show up as a wrong result or a late done, so this run separates ignoring the request from honouring it. Another run starts in the very cycle done is high, which shows whether the idle state is re-entered at once.

// File: rtl/aes_loop_pkg.sv
`timescale 1ns/1ps
package aes_loop_pkg;

   localparam int BLK_W  = 128;
   localparam int BYTE_W = 8;
   localparam int NBYTES = BLK_W / BYTE_W;

   function automatic logic [7:0] xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] aa;
      logic [7:0] bb;
      p  = 8'h00;
      aa = a;
      bb = b;
      for (int i = 0; i < 8; i++) begin
         if (bb[0]) p = p ^ aa;
         aa = xtime(aa);
         bb = {1'b0, bb[7:1]};
      end
      return p;
   endfunction

   // x^254 in GF(2^8) gives the multiplicative inverse (0 maps to 0)
   function automatic logic [7:0] gf_inv(input logic [7:0] x);
      logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
      x2   = gf_mul(x, x);
      x3   = gf_mul(x2, x);
      x6   = gf_mul(x3, x3);
      x12  = gf_mul(x6, x6);
      x15  = gf_mul(x12, x3);
      x30  = gf_mul(x15, x15);
      x60  = gf_mul(x30, x30);
      x120 = gf_mul(x60, x60);
      x240 = gf_mul(x120, x120);
      x252 = gf_mul(x240, x12);
      return gf_mul(x252, x2);
   endfunction

   function automatic logic [7:0] sbox_fn(input logic [7:0] x);
      logic [7:0] v;
      v = gf_inv(x);
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/aes_sub_lanes.sv
`timescale 1ns/1ps
module aes_sub_lanes #(
   parameter int LANES = 16
) (
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   import aes_loop_pkg::*;

   if (LANES < 1) begin : g_bad_lanes
      $error("aes_sub_lanes: LANES must be at least 1");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dout[8*l +: 8] = sbox_fn(din[8*l +: 8]);
   end
endmodule

// File: rtl/aes_key_step.sv
`timescale 1ns/1ps
module aes_key_step #(
   parameter int WORDS = 4
) (
   input  logic [32*WORDS-1:0] key_in,
   input  logic [7:0]          rcon,
   output logic [32*WORDS-1:0] key_out
);
   localparam int KW = 32 * WORDS;

   logic [31:0] last_w;
   logic [31:0] sub_w;
   logic [31:0] mix_w;
   logic [31:0] nw [WORDS];

   if (WORDS != 4) begin : g_bad_words
      $error("aes_key_step: only four-word keys are supported");
   end

   assign last_w = key_in[31:0];

   aes_sub_lanes #(.LANES(4)) u_sub (
      .din  ({last_w[23:0], last_w[31:24]}),
      .dout (sub_w)
   );

   assign mix_w = sub_w ^ {rcon, 24'h000000};

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      if (w == 0) begin : g_first
         assign nw[w] = key_in[KW-1 -: 32] ^ mix_w;
      end else begin : g_chain
         assign nw[w] = key_in[KW-1-32*w -: 32] ^ nw[w-1];
      end
      assign key_out[KW-1-32*w -: 32] = nw[w];
   end
endmodule

// File: rtl/aes_round_xform.sv
`timescale 1ns/1ps
module aes_round_xform (
   input  logic [127:0] s_in,
   input  logic         skip_mix,
   output logic [127:0] s_out
);
   import aes_loop_pkg::*;

   logic [7:0] sr [16];
   logic [7:0] mc [16];

   // byte k sits at bits 127-8k; state (row r, col c) is byte r+4c
   for (genvar c = 0; c < 4; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         assign sr[r+4*c] = s_in[127-8*(r+4*((c+r)%4)) -: 8];
      end
      assign mc[4*c+0] = xtime(sr[4*c+0]) ^ gf_mul(sr[4*c+1], 8'h03) ^ sr[4*c+2] ^ sr[4*c+3];
      assign mc[4*c+1] = sr[4*c+0] ^ xtime(sr[4*c+1]) ^ gf_mul(sr[4*c+2], 8'h03) ^ sr[4*c+3];
      assign mc[4*c+2] = sr[4*c+0] ^ sr[4*c+1] ^ xtime(sr[4*c+2]) ^ gf_mul(sr[4*c+3], 8'h03);
      assign mc[4*c+3] = gf_mul(sr[4*c+0], 8'h03) ^ sr[4*c+1] ^ sr[4*c+2] ^ xtime(sr[4*c+3]);
   end

   for (genvar k = 0; k < 16; k++) begin : g_out
      assign s_out[127-8*k -: 8] = skip_mix ? sr[k] : mc[k];
   end
endmodule

// File: rtl/aes128_loop_enc.sv
`timescale 1ns/1ps
module aes128_loop_enc #(
   parameter int ROUNDS = 10,
   parameter int KEY_W  = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [127:0]       pt_i,
   input  logic [KEY_W-1:0]   key_i,
   output logic [127:0]       ct_o,
   output logic               done_o,
   output logic               trig_o
);
   import aes_loop_pkg::*;

   localparam int CNT_W = $clog2(ROUNDS + 1);

   if (ROUNDS != 10) begin : g_bad_rounds
      $error("aes128_loop_enc: a 128-bit key needs ROUNDS = 10");
   end
   if (KEY_W != BLK_W) begin : g_bad_key
      $error("aes128_loop_enc: KEY_W must be 128");
   end

   logic [127:0]     sb_q;
   logic [KEY_W-1:0] key_q;
   logic [7:0]       rcon_q;
   logic [CNT_W-1:0] rnd_q;
   logic             busy_q;
   logic             done_q;
   logic [127:0]     ct_q;

   logic             load;
   logic             last;
   logic [KEY_W-1:0] rk;
   logic [KEY_W-1:0] key_nx;
   logic [127:0]     xf_out;
   logic [127:0]     ark_in;
   logic [127:0]     ark_out;
   logic [127:0]     sb_d;

   assign load = start_i && !busy_q;
   assign last = busy_q && (rnd_q == CNT_W'(ROUNDS));
   assign rk   = load ? key_i : key_q;

   aes_round_xform u_xf (
      .s_in     (sb_q),
      .skip_mix (last),
      .s_out    (xf_out)
   );

   // loop selector: plaintext on the first round, state afterwards
   assign ark_in  = load ? pt_i : xf_out;
   assign ark_out = ark_in ^ rk;

   aes_sub_lanes #(.LANES(NBYTES)) u_sub (
      .din  (ark_out),
      .dout (sb_d)
   );

   aes_key_step #(.WORDS(KEY_W/32)) u_key (
      .key_in  (rk),
      .rcon    (load ? 8'h01 : rcon_q),
      .key_out (key_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_q   <= '0;
         key_q  <= '0;
         rcon_q <= 8'h00;
         rnd_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ct_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            sb_q   <= sb_d;
            key_q  <= key_nx;
            rcon_q <= xtime(8'h01);
            rnd_q  <= CNT_W'(1);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (last) begin
               ct_q   <= ark_out;
               done_q <= 1'b1;
               busy_q <= 1'b0;
            end else begin
               sb_q   <= sb_d;
               key_q  <= key_nx;
               rcon_q <= xtime(rcon_q);
               rnd_q  <= rnd_q + CNT_W'(1);
            end
         end
      end
   end

   assign ct_o   = ct_q;
   assign done_o = done_q;
   assign trig_o = busy_q;
endmodule

// File: rtl/aes128_loop_chk.sv
`timescale 1ns/1ps
module aes128_loop_chk #(
   parameter int ROUNDS = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [127:0] ct_o,
   input logic         done_o,
   input logic         trig_o
);
   localparam int CW = $clog2(ROUNDS + 2);

   logic [CW-1:0] act_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_cnt <= '0;
      else if (trig_o) act_cnt <= act_cnt + CW'(1);
      else             act_cnt <= '0;
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ct_o) |-> $rose(done_o));

   // R6
   trig_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_o && done_o));

   // R7
   trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_o) |-> ($past(start_i) && !$past(trig_o)));

   // R8
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !trig_o) |=> trig_o);

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (act_cnt == CW'(ROUNDS)));
endmodule

bind aes128_loop_enc aes128_loop_chk #(.ROUNDS(ROUNDS)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .ct_o    (ct_o),
   .done_o  (done_o),
   .trig_o  (trig_o)
);

// File: tb/aes128_loop_enc_tb_top.sv
`timescale 1ns/1ps
module aes128_loop_enc_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [127:0] pt_i = '0;
   logic [127:0] key_i = '0;
   logic [127:0] ct_o;
   logic         done_o;
   logic         trig_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int tcnt = 0;
   int n_done = 0;
   bit finished = 1'b0;

   logic [127:0] exp_ct_q [$];
   int           exp_cy_q [$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   aes128_loop_enc dut_i (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .pt_i (pt_i),
      .key_i (key_i), .ct_o (ct_o), .done_o (done_o), .trig_o (trig_o)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: called at a falling edge, pushes the expected result
   task automatic drive(input logic [127:0] pt, input logic [127:0] key,
                        input logic [127:0] ct);
      pt_i    = pt;
      key_i   = key;
      start_i = 1'b1;
      exp_ct_q.push_back(ct);
      exp_cy_q.push_back(cyc + 1);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 40 && !done_o; i++) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (trig_o) tcnt++;
         if (done_o) begin
            n_done++;
            check(!trig_o, "R6 trig low at done", 128'(trig_o), 128'd0);
            check(tcnt == 10, "R6 trig high cycles", 128'(tcnt), 128'd10);
            tcnt = 0;
            if (exp_ct_q.size() == 0) begin
               check(1'b0, "R7 unexpected done", 128'd1, 128'd0);
            end else begin
               logic [127:0] e;
               int c0;
               e  = exp_ct_q.pop_front();
               c0 = exp_cy_q.pop_front();
               check(ct_o == e, "R2 ciphertext", ct_o, e);
               check(cyc == c0 + 10, "R3 latency", 128'(cyc), 128'(c0 + 10));
            end
         end
      end
   end

   initial begin
      #(20.0 * 200000);
      check(1'b0, "watchdog expired", 128'd0, 128'd1);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [127:0] held;
      int c_start;
      repeat (3) @(negedge clk);
      check(done_o == 1'b0 && trig_o == 1'b0, "R1 flags in reset",
            {126'd0, done_o, trig_o}, 128'd0);
      check(ct_o == '0, "R1 ct in reset", ct_o, 128'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done_o == 1'b0 && trig_o == 1'b0 && ct_o == '0, "R1 idle after reset",
            ct_o ^ {126'd0, done_o, trig_o}, 128'd0);

      drive(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
      wait_done();
      held = ct_o;
      @(negedge clk);
      check(done_o == 1'b0, "R4 done one cycle", 128'(done_o), 128'd0);
      repeat (4) @(negedge clk);
      check(ct_o == held, "R5 ct held", ct_o, held);

      drive(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            128'h3925841d02dc09fbdc118597196a0b32);
      wait_done();
      // R8: new start in the cycle done is high
      c_start = cyc + 1;
      drive(128'h6bc1bee22e409f96e93d7e117393172a, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            128'h3ad77bb40d7a3660a89ecaf32466ef97);
      wait_done();
      check(cyc == c_start + 10, "R8 back-to-back start", 128'(cyc), 128'(c_start + 10));
      @(negedge clk);

      // R7: a second start mid-run must be ignored
      drive(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
      repeat (3) @(negedge clk);
      pt_i    = 128'h00112233445566778899aabbccddeeff;
      key_i   = 128'h000102030405060708090a0b0c0d0e0f;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      check(n_done == 4, "R7 done count", 128'(n_done), 128'd4);
      check(ct_o == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e && trig_o == 1'b0,
            "R7 result kept", ct_o, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
      check(exp_ct_q.size() == 0, "R2 all results seen", 128'(exp_ct_q.size()), 128'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule